// File: doc/BRIEF.md
# Exception Nomination Controller

This block keeps the pending and active state of every exception a small processor core can take, and decides which one the core should enter next. Requests arrive from a configurable number of level-sensitive interrupt lines, a non-maskable interrupt line, a fault indication, a warm-reset request, a supervisor-call request, a periodic tick and a software pend bit. Each request is latched into a pending bit. A simple write port holds a 2-bit urgency for every configurable exception and a global mask that holds back all configurable exceptions during critical regions.

A three-state machine drives the core handshake. In `ST_RUN` the block compares the most urgent eligible pending exception with the current execution level. If the pending one is strictly more urgent, the machine moves to `ST_OFFER` (transition *nominate*) and raises `take_req_o` with the exception number. While in `ST_OFFER`, a request that arrives later and is strictly more urgent replaces the nominee (transition *late switch*). An acknowledge returns the machine to `ST_RUN` (transition *enter*). If the offer stops beating the current level, the machine also returns to `ST_RUN` (transition *withdraw*). A return pulse in `ST_RUN` pops the newest active exception and passes through `ST_UNWIND` for one cycle (transitions *return* and *resume*).

Entering the reset exception flushes all pending bits, the active stack, the priorities and the mask. This puts the core back in thread mode.

Top module: `exc_nominator`

## Requirements
- R1: While `rst_n` is low, `exec_level_o` is 7, `handler_o` is 0 and `take_req_o` is 0. After `rst_n` is released, the reset exception (number 1) is pending and is offered.
- R2: Acknowledging exception 1 clears every pending bit, the active stack, all priorities and the mask. Afterwards `exec_level_o` is 7 (thread), `handler_o` is 0 and no offer follows.
- R3: Exception numbers are: 1 reset, 2 non-maskable, 3 fault, 11 supervisor call, 14 software pend, 15 tick, and 16+i for interrupt line i. No other number is ever offered.
- R4: Execution level encoding: 1 non-maskable, 2 fault, 3+p for a configurable exception with priority p (0..3), 7 thread. Reset is more urgent than level 1. A lower level is more urgent. Fixed exceptions outrank every configurable one.
- R5: Among pending exceptions of equal level, the lowest exception number is chosen.
- R6: A pending exception is offered only when its level is strictly below the current execution level.
- R7: While the mask is set, configurable exceptions stay pending but are not offered. Reset, non-maskable and fault are unaffected.
- R8: The non-maskable interrupt is offered regardless of mask or active configurable exceptions. While it is active, only reset is offered.
- R9: The software pend exception (14) is set only by `pend_sw_i`.
- R10: While offering, a newly pending exception of strictly lower level replaces the nominee. One of equal level does not.
- R11: On acknowledge, the offered exception's pending bit clears and it is pushed as active, and `exec_level_o` and `act_num_o` show it. A `ret_i` pulse pops it and restores the previous level.
- R12: A one-cycle pulse on an interrupt line leaves the exception pending until it is taken.
- R13: Priority registers of configurable exceptions read back what was written. Those of every other number read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_i | input | N_IRQ | Level-sensitive external interrupt lines |
| nmi_i | input | 1 | Non-maskable interrupt request |
| fault_i | input | 1 | Fault indication |
| wrst_i | input | 1 | Warm-reset exception request |
| svc_i | input | 1 | Supervisor-call request |
| tick_i | input | 1 | Periodic tick event |
| pend_sw_i | input | 1 | Software write of the pend-request bit |
| mask_we_i | input | 1 | Mask register write strobe |
| mask_val_i | input | 1 | Mask value to write |
| prio_we_i | input | 1 | Priority write strobe |
| prio_waddr_i | input | EXC_W | Exception number whose priority is written |
| prio_wdata_i | input | 2 | Priority value |
| prio_raddr_i | input | EXC_W | Exception number whose priority is read |
| prio_rdata_o | output | 2 | Priority read data |
| take_req_o | output | 1 | Request to the core to enter an exception |
| take_num_o | output | EXC_W | Nominated exception number |
| ack_i | input | 1 | Core accepts the offered exception |
| ret_i | input | 1 | Core returns from the newest active exception |
| exec_level_o | output | 3 | Current execution level |
| act_num_o | output | EXC_W | Newest active exception number, 0 in thread mode |
| handler_o | output | 1 | At least one exception is active |

## Verification
The selection logic is exercised with these patterns:
- Simultaneous pulses that differ only in fixed rank (fault with supervisor call). This separates the fixed ordering from the configurable ordering.
- Equal-level pairs (tick with line 0). These expose the tie-break and the strict-preemption rule once one of the pair is active.
- Masked configurable requests mixed with fault, non-maskable and reset requests. These show that the mask holds back only configurable exceptions, and that an active non-maskable interrupt yields only to reset.

A staged arrival during an open offer tells apart a switch to a strictly more urgent request from a wrongful switch on an equal-level request.

// File: rtl/exc_pkg.sv
package exc_pkg;

    localparam int          FIRST_EXT   = 16;
    localparam logic [2:0]  RANK_RESET  = 3'd0;
    localparam logic [2:0]  RANK_NMI    = 3'd1;
    localparam logic [2:0]  RANK_FAULT  = 3'd2;
    localparam logic [2:0]  RANK_CFG0   = 3'd3;
    localparam logic [2:0]  RANK_THREAD = 3'd7;
    // nesting bound: non-maskable, fault and four configurable levels
    localparam int          NEST_MAX    = 6;

    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_OFFER  = 2'd1,
        ST_UNWIND = 2'd2
    } nom_state_e;

    function automatic bit is_cfg(input int n);
        return (n == 11) || (n == 14) || (n == 15) || (n >= FIRST_EXT);
    endfunction

    function automatic bit is_impl(input int n);
        return ((n >= 1) && (n <= 3)) || is_cfg(n);
    endfunction

    function automatic logic [2:0] rank_of(input int n, input logic [1:0] p);
        if (n == 1)      return RANK_RESET;
        else if (n == 2) return RANK_NMI;
        else if (n == 3) return RANK_FAULT;
        else             return RANK_CFG0 + {1'b0, p};
    endfunction

endpackage

// File: rtl/exc_prio_regs.sv
module exc_prio_regs
    import exc_pkg::*;
#(
    parameter int NUM_EXC = 24,
    parameter int EXC_W   = 5
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   flush_i,
    input  logic                   we_i,
    input  logic [EXC_W-1:0]       waddr_i,
    input  logic [1:0]             wdata_i,
    input  logic [EXC_W-1:0]       raddr_i,
    output logic [1:0]             rdata_o,
    input  logic                   mask_we_i,
    input  logic                   mask_val_i,
    output logic                   mask_o,
    output logic [NUM_EXC-1:0][1:0] prio_o
);

    for (genvar n = 0; n < NUM_EXC; n++) begin : g_prio
        if (is_cfg(n)) begin : g_cfg
            localparam logic [EXC_W-1:0] IDX = EXC_W'(n);
            logic [1:0] q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                        q <= 2'b00;
                else if (flush_i)                  q <= 2'b00;
                else if (we_i && waddr_i == IDX)   q <= wdata_i;
            end
            assign prio_o[n] = q;
        end else begin : g_fixed
            assign prio_o[n] = 2'b00;
        end
    end

    always_comb begin
        if (int'(raddr_i) < NUM_EXC) rdata_o = prio_o[raddr_i];
        else                         rdata_o = 2'b00;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         mask_o <= 1'b0;
        else if (flush_i)   mask_o <= 1'b0;
        else if (mask_we_i) mask_o <= mask_val_i;
    end

endmodule

// File: rtl/exc_pending.sv
module exc_pending
    import exc_pkg::*;
#(
    parameter int NUM_EXC = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush_i,
    input  logic [NUM_EXC-1:0] set_i,
    input  logic [NUM_EXC-1:0] clr_i,
    output logic [NUM_EXC-1:0] pend_o
);

    for (genvar n = 0; n < NUM_EXC; n++) begin : g_pend
        if (is_impl(n)) begin : g_impl
            localparam logic RST_VAL = (n == 1);
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)         pend_o[n] <= RST_VAL;
                else if (flush_i)   pend_o[n] <= 1'b0;
                else if (clr_i[n])  pend_o[n] <= 1'b0;
                else if (set_i[n])  pend_o[n] <= 1'b1;
            end

            AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
                clr_i[n] |=> !pend_o[n]); // R11
        end else begin : g_rsvd
            logic unused_in;
            assign unused_in = set_i[n] | clr_i[n];
            assign pend_o[n] = 1'b0;
        end
    end

endmodule

// File: rtl/exc_select.sv
module exc_select
    import exc_pkg::*;
#(
    parameter int NUM_EXC = 24,
    parameter int EXC_W   = 5
) (
    input  logic [NUM_EXC-1:0]      pend_i,
    input  logic [NUM_EXC-1:0][1:0] prio_i,
    input  logic                    mask_i,
    output logic                    win_valid_o,
    output logic [EXC_W-1:0]        win_num_o,
    output logic [2:0]              win_rank_o
);

    always_comb begin
        logic [2:0] r;
        win_valid_o = 1'b0;
        win_num_o   = '0;
        win_rank_o  = RANK_THREAD;
        // descending scan with <= leaves the lowest number among equal levels
        for (int n = NUM_EXC - 1; n >= 0; n--) begin
            r = rank_of(n, prio_i[n]);
            if (pend_i[n] && is_impl(n) && (!is_cfg(n) || !mask_i) &&
                (!win_valid_o || r <= win_rank_o)) begin
                win_valid_o = 1'b1;
                win_num_o   = EXC_W'(n);
                win_rank_o  = r;
            end
        end
    end

endmodule

// File: rtl/exc_active_stack.sv
module exc_active_stack
    import exc_pkg::*;
#(
    parameter int EXC_W = 5,
    parameter int DEPTH = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic [EXC_W-1:0] push_num_i,
    input  logic [2:0]       push_rank_i,
    input  logic             pop_i,
    input  logic             flush_i,
    output logic [2:0]       cur_rank_o,
    output logic [EXC_W-1:0] top_num_o,
    output logic             busy_o
);

    localparam int CW = $clog2(DEPTH + 1);

    logic [EXC_W-1:0] num_q  [DEPTH];
    logic [2:0]       rank_q [DEPTH];
    logic [CW-1:0]    cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          cnt_q <= '0;
        else if (flush_i)                    cnt_q <= '0;
        else if (push_i && int'(cnt_q) < DEPTH) cnt_q <= cnt_q + 1'b1;
        else if (pop_i && cnt_q != '0)       cnt_q <= cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (push_i && !flush_i && int'(cnt_q) < DEPTH) begin
            num_q[cnt_q]  <= push_num_i;
            rank_q[cnt_q] <= push_rank_i;
        end
    end

    always_comb begin
        busy_o = (cnt_q != '0);
        if (busy_o) begin
            cur_rank_o = rank_q[cnt_q - 1'b1];
            top_num_o  = num_q[cnt_q - 1'b1];
        end else begin
            cur_rank_o = RANK_THREAD;
            top_num_o  = '0;
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> int'(cnt_q) < DEPTH); // R11

endmodule

// File: rtl/exc_nominator.sv
module exc_nominator
    import exc_pkg::*;
#(
    parameter int N_IRQ = 8,
    parameter int EXC_W = $clog2(FIRST_EXT + N_IRQ)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_IRQ-1:0] irq_i,
    input  logic             nmi_i,
    input  logic             fault_i,
    input  logic             wrst_i,
    input  logic             svc_i,
    input  logic             tick_i,
    input  logic             pend_sw_i,
    input  logic             mask_we_i,
    input  logic             mask_val_i,
    input  logic             prio_we_i,
    input  logic [EXC_W-1:0] prio_waddr_i,
    input  logic [1:0]       prio_wdata_i,
    input  logic [EXC_W-1:0] prio_raddr_i,
    output logic [1:0]       prio_rdata_o,
    output logic             take_req_o,
    output logic [EXC_W-1:0] take_num_o,
    input  logic             ack_i,
    input  logic             ret_i,
    output logic [2:0]       exec_level_o,
    output logic [EXC_W-1:0] act_num_o,
    output logic             handler_o
);

    localparam int NUM_EXC = FIRST_EXT + N_IRQ;

    nom_state_e                state_q, state_d;
    logic [EXC_W-1:0]          nom_q;
    logic [2:0]                nom_rank_q;
    logic [NUM_EXC-1:0]        set_vec, clr_vec, pend;
    logic [NUM_EXC-1:0][1:0]   prio;
    logic                      mask;
    logic                      win_valid, beats;
    logic [EXC_W-1:0]          win_num;
    logic [2:0]                win_rank, cur_rank;
    logic                      ack_fire, push, pop, flush;

    // request sources onto exception numbers
    always_comb begin
        set_vec     = '0;
        set_vec[1]  = wrst_i;
        set_vec[2]  = nmi_i;
        set_vec[3]  = fault_i;
        set_vec[11] = svc_i;
        set_vec[14] = pend_sw_i;
        set_vec[15] = tick_i;
        for (int i = 0; i < N_IRQ; i++) set_vec[FIRST_EXT + i] = irq_i[i];
    end

    always_comb begin
        clr_vec = '0;
        if (ack_fire) clr_vec[nom_q] = 1'b1;
    end

    exc_prio_regs #(.NUM_EXC(NUM_EXC), .EXC_W(EXC_W)) u_prio (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush_i    (flush),
        .we_i       (prio_we_i),
        .waddr_i    (prio_waddr_i),
        .wdata_i    (prio_wdata_i),
        .raddr_i    (prio_raddr_i),
        .rdata_o    (prio_rdata_o),
        .mask_we_i  (mask_we_i),
        .mask_val_i (mask_val_i),
        .mask_o     (mask),
        .prio_o     (prio)
    );

    exc_pending #(.NUM_EXC(NUM_EXC)) u_pend (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush_i (flush),
        .set_i   (set_vec),
        .clr_i   (clr_vec),
        .pend_o  (pend)
    );

    exc_select #(.NUM_EXC(NUM_EXC), .EXC_W(EXC_W)) u_sel (
        .pend_i      (pend),
        .prio_i      (prio),
        .mask_i      (mask),
        .win_valid_o (win_valid),
        .win_num_o   (win_num),
        .win_rank_o  (win_rank)
    );

    exc_active_stack #(.EXC_W(EXC_W), .DEPTH(NEST_MAX)) u_stack (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (push),
        .push_num_i  (nom_q),
        .push_rank_i (nom_rank_q),
        .pop_i       (pop),
        .flush_i     (flush),
        .cur_rank_o  (cur_rank),
        .top_num_o   (act_num_o),
        .busy_o      (handler_o)
    );

    assign beats = win_valid && (win_rank < cur_rank);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (ret_i && handler_o) state_d = ST_UNWIND;  // return
                else if (beats)         state_d = ST_OFFER;   // nominate
            end
            ST_OFFER: begin
                if (ack_i)              state_d = ST_RUN;     // enter
                else if (!beats)        state_d = ST_RUN;     // withdraw
            end
            ST_UNWIND:                  state_d = ST_RUN;     // resume
            default:                    state_d = ST_RUN;
        endcase
    end

    // nominee register, including the late switch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nom_q      <= '0;
            nom_rank_q <= RANK_THREAD;
        end else if (state_q == ST_RUN && state_d == ST_OFFER) begin
            nom_q      <= win_num;
            nom_rank_q <= win_rank;
        end else if (state_q == ST_OFFER && !ack_i && beats && win_rank < nom_rank_q) begin
            nom_q      <= win_num;
            nom_rank_q <= win_rank;
        end
    end

    // outputs
    always_comb begin
        take_req_o   = (state_q == ST_OFFER);
        take_num_o   = nom_q;
        ack_fire     = take_req_o && ack_i;
        flush        = ack_fire && (nom_q == EXC_W'(1));
        push         = ack_fire && !flush;
        pop          = (state_q == ST_RUN) && ret_i && handler_o;
        exec_level_o = cur_rank;
    end

    AST_OFFER_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        take_req_o |-> is_impl(int'(take_num_o))); // R3
    AST_OFFER_STRICT: assert property (@(posedge clk) disable iff (!rst_n)
        take_req_o |-> nom_rank_q < cur_rank); // R6
    AST_MASK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (mask && $past(mask) && take_req_o) |-> !is_cfg(int'(take_num_o))); // R7
    AST_NMI_YIELDS_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        (handler_o && act_num_o == EXC_W'(2) && take_req_o) |-> take_num_o == EXC_W'(1)); // R8
    AST_LATE_UPGRADE: assert property (@(posedge clk) disable iff (!rst_n)
        (take_req_o && $past(take_req_o) && !$past(ack_i) && take_num_o != $past(take_num_o))
        |-> nom_rank_q < $past(nom_rank_q)); // R10

endmodule

// File: tb/test_exc_nominator.sv
module test_exc_nominator;

    localparam int N_IRQ = 8;
    localparam int W     = 5;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [N_IRQ-1:0] irq_i = '0;
    logic nmi_i = 0, fault_i = 0, wrst_i = 0, svc_i = 0, tick_i = 0, pend_sw_i = 0;
    logic mask_we_i = 0, mask_val_i = 0, prio_we_i = 0, ack_i = 0, ret_i = 0;
    logic [W-1:0] prio_waddr_i = '0, prio_raddr_i = '0;
    logic [1:0]   prio_wdata_i = '0;
    logic [1:0]   prio_rdata_o;
    logic         take_req_o, handler_o;
    logic [W-1:0] take_num_o, act_num_o;
    logic [2:0]   exec_level_o;

    int    n_chk = 0, n_bad = 0;
    int    exp_q[$];
    string tag_q[$];
    bit    want_ack = 0;

    always #5 clk = ~clk;

    exc_nominator #(.N_IRQ(N_IRQ)) i_exc_nominator (
        .clk(clk), .rst_n(rst_n), .irq_i(irq_i), .nmi_i(nmi_i), .fault_i(fault_i),
        .wrst_i(wrst_i), .svc_i(svc_i), .tick_i(tick_i), .pend_sw_i(pend_sw_i),
        .mask_we_i(mask_we_i), .mask_val_i(mask_val_i), .prio_we_i(prio_we_i),
        .prio_waddr_i(prio_waddr_i), .prio_wdata_i(prio_wdata_i),
        .prio_raddr_i(prio_raddr_i), .prio_rdata_o(prio_rdata_o),
        .take_req_o(take_req_o), .take_num_o(take_num_o), .ack_i(ack_i), .ret_i(ret_i),
        .exec_level_o(exec_level_o), .act_num_o(act_num_o), .handler_o(handler_o)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    // monitor: pops the expected number when the offer appears and acknowledges it
    initial begin
        forever begin
            @(negedge clk);
            ack_i = 1'b0;
            if (want_ack && take_req_o) begin
                check(tag_q.pop_front(), int'(take_num_o), exp_q.pop_front());
                ack_i    = 1'b1;
                want_ack = 1'b0;
            end
        end
    end

    // driver: queue an expected entry and wait for the monitor to consume it
    task automatic take(input int num, input string tag);
        exp_q.push_back(num);
        tag_q.push_back(tag);
        want_ack = 1'b1;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (!want_ack) break;
        end
        if (want_ack) begin
            want_ack = 1'b0;
            void'(exp_q.pop_front());
            void'(tag_q.pop_front());
            n_chk++; n_bad++;
            $display("FAIL %s: got no offer expected %0d", tag, num);
        end
        @(negedge clk);
    endtask

    task automatic no_take(input int cyc, input string tag);
        int seen = 0;
        for (int k = 0; k < cyc; k++) begin
            @(negedge clk);
            if (take_req_o) seen = 1;
        end
        check(tag, seen, 0);
    endtask

    task automatic ret_pulse();
        ret_i = 1'b1;
        @(negedge clk);
        ret_i = 1'b0;
        @(negedge clk);
    endtask

    task automatic wr_prio(input int num, input int val);
        prio_we_i = 1'b1; prio_waddr_i = W'(num); prio_wdata_i = 2'(val);
        @(negedge clk);
        prio_we_i = 1'b0;
    endtask

    task automatic rd_prio(input int num, input int exp, input string tag);
        prio_raddr_i = W'(num);
        #1;
        check(tag, int'(prio_rdata_o), exp);
    endtask

    task automatic set_mask(input bit v);
        mask_we_i = 1'b1; mask_val_i = v;
        @(negedge clk);
        mask_we_i = 1'b0;
    endtask

    task automatic wait_offer();
        for (int k = 0; k < 20; k++) begin
            if (take_req_o) break;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        // R1 reset state and reset offer
        repeat (3) @(negedge clk);
        check("R1 level in reset", int'(exec_level_o), 7);
        check("R1 handler in reset", int'(handler_o), 0);
        check("R1 no offer in reset", int'(take_req_o), 0);
        rst_n = 1'b1;
        take(1, "R1 reset offered");
        check("R2 thread level", int'(exec_level_o), 7);
        check("R2 no handler", int'(handler_o), 0);
        no_take(3, "R2 nothing after reset");

        // R13 priority register access
        wr_prio(3, 3);  rd_prio(3, 0, "R13 fault prio reads 0");
        wr_prio(5, 2);  rd_prio(5, 0, "R13 reserved reads 0");
        wr_prio(11, 2); rd_prio(11, 2, "R13 svc prio readback");
        wr_prio(11, 0);

        // R12 / R11 pulsed line, enter and return
        wr_prio(19, 2);
        irq_i[3] = 1'b1; @(negedge clk); irq_i[3] = 1'b0;
        take(19, "R12 pulsed line taken");
        check("R11 level after entry", int'(exec_level_o), 5);
        check("R11 active number", int'(act_num_o), 19);
        check("R11 handler", int'(handler_o), 1);
        ret_pulse();
        check("R11 level after return", int'(exec_level_o), 7);
        check("R11 handler after return", int'(handler_o), 0);

        // R5 tie and R6 strict preemption
        tick_i = 1'b1; irq_i[0] = 1'b1; @(negedge clk); tick_i = 1'b0; irq_i[0] = 1'b0;
        take(15, "R5 lowest number wins tie");
        no_take(4, "R6 equal level does not preempt");
        ret_pulse();
        take(16, "R5 second of tie");
        ret_pulse();

        // R4 fixed ordering and nesting
        fault_i = 1'b1; svc_i = 1'b1; @(negedge clk); fault_i = 1'b0; svc_i = 1'b0;
        take(3, "R4 R3 fault before svc");
        check("R4 fault level", int'(exec_level_o), 2);
        nmi_i = 1'b1; @(negedge clk); nmi_i = 1'b0;
        take(2, "R4 nmi preempts fault");
        check("R4 nmi level", int'(exec_level_o), 1);
        ret_pulse();
        check("R11 restore fault level", int'(exec_level_o), 2);
        ret_pulse();
        take(11, "R3 svc number");
        check("R4 svc level", int'(exec_level_o), 3);
        ret_pulse();

        // R7 mask
        set_mask(1'b1);
        irq_i[1] = 1'b1; @(negedge clk); irq_i[1] = 1'b0;
        no_take(4, "R7 masked line held");
        fault_i = 1'b1; @(negedge clk); fault_i = 1'b0;
        take(3, "R7 fault ignores mask");
        ret_pulse();
        no_take(3, "R7 still masked");
        set_mask(1'b0);
        take(17, "R12 R7 pending kept through mask");
        ret_pulse();

        // R8 non-maskable and reset preemption, R2 flush
        set_mask(1'b1);
        nmi_i = 1'b1; @(negedge clk); nmi_i = 1'b0;
        take(2, "R8 nmi under mask");
        fault_i = 1'b1; @(negedge clk); fault_i = 1'b0;
        no_take(4, "R8 fault cannot preempt nmi");
        wrst_i = 1'b1; @(negedge clk); wrst_i = 1'b0;
        take(1, "R8 reset preempts nmi");
        check("R2 level after warm reset", int'(exec_level_o), 7);
        check("R2 stack flushed", int'(handler_o), 0);
        no_take(4, "R2 fault pending flushed");
        rd_prio(19, 0, "R2 priority cleared");
        irq_i[0] = 1'b1; @(negedge clk); irq_i[0] = 1'b0;
        take(16, "R2 mask cleared");
        ret_pulse();

        // R9 software pend
        pend_sw_i = 1'b1; @(negedge clk); pend_sw_i = 1'b0;
        take(14, "R9 software pend");
        ret_pulse();

        // R10 late arrival
        wr_prio(16, 2); wr_prio(18, 2); wr_prio(17, 1);
        irq_i[2] = 1'b1; @(negedge clk); irq_i[2] = 1'b0;
        wait_offer();
        check("R10 first nominee", int'(take_num_o), 18);
        irq_i[0] = 1'b1; @(negedge clk); irq_i[0] = 1'b0;
        repeat (2) @(negedge clk);
        check("R10 equal level keeps nominee", int'(take_num_o), 18);
        irq_i[1] = 1'b1; @(negedge clk); irq_i[1] = 1'b0;
        repeat (2) @(negedge clk);
        check("R10 switch to more urgent", int'(take_num_o), 17);
        take(17, "R10 switched nominee entered");
        check("R10 level", int'(exec_level_o), 4);
        ret_pulse();
        take(16, "R5 tie after return");
        ret_pulse();
        take(18, "R10 remaining request");
        ret_pulse();
        no_take(4, "R6 idle at end");

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule